// File: doc/BRIEF.md
# Paired-page TLB translation unit

This block is a small, fully associative translation lookaside buffer for a processor whose memory model has two unmapped kernel windows and mapped regions everywhere else. Each entry maps a pair of adjacent pages, one even and one odd. The pair is located by a virtual page number, a per-entry page-size mask and an address-space tag, and a global bit can make an entry match every tag. Each half of the pair has its own frame number, valid bit, dirty bit and cache attribute.

A translation port accepts one request per cycle. A request carries a virtual address, an address-space tag, an access kind, an access size and the processor status word. One cycle later the unit returns either a physical address or a fault code. For faults the refill handler needs, the unit also returns the virtual-page and context values. Addresses in the two kernel windows bypass the table.

A maintenance port writes entries, either at an explicit slot or at a round-robin slot. It can also probe the table for a tag and clear the whole table.

Top module: `tlb_pair_xlate`

## Requirements
- R1: An entry matches a lookup only after it has been written since the last reset or clear. It matches when the lookup page number equals the stored page number on every bit outside the entry's size mask. The size mask covers page-number bits [9:2]. The entry must also either have its global bit set or hold the request's tag.
- R2: The lookup page number is address bits [31:11] with its two low bits forced to zero. When `fine_pages` is high, those two low bits are kept instead.
- R3: The entry's size mask must be 0x00, 0x03, 0x0F, 0x3F or 0xFF. The page shift is 12 plus the mask's bit count rounded down to even. The address bit at that shift selects the odd half (1) or the even half (0).
- R4: On success, the physical address is the selected frame number times 4096, with the bits below the page shift cleared and replaced by the same bits of the virtual address. `rsp_cattr` is the selected half's cache attribute.
- R5: Fault codes are 0 none, 1 fetch address error, 2 data address error, 3 fetch refill, 4 data refill, 5 fetch invalid and 6 data invalid. A mapped access with no matching entry is a refill. A match whose selected half is not valid is invalid. Access kinds are 0 load, 1 store and 2 fetch.
- R6: Code 7, the modified fault, is raised only for a store whose selected half is valid but not dirty. Loads and fetches are never given code 7.
- R7: For codes 3 to 7 the response carries the following: the full virtual address, page-pair number = lookup page number >> 2, `rsp_vpn2x` = lookup page number & 3, the request tag, and the context page-pair number equal to the page-pair number. For code 0 the bad address and these fields are zero.
- R8: Addresses with bits [31:29] = 100 or 101 bypass the table, and the physical address is bits [28:0]. A 100 access gives an address error if the mode is not kernel or the access is misaligned. A 101 access never faults.
- R9: The mode is kernel when (status & 0x10000006) is nonzero or status bits [4:3] are 00. Bits [4:3] = 01 is supervisor and 10 is user.
- R10: `rsp_uncached` is set on a successful translation when address bits 31 and 29 are both set. A misaligned mapped access is an address error even if the table would hit. Sizes are 0 byte, 1 half, 2 word and 3 double.
- R11: A probe (op 3) returns, one cycle later, the lowest matching slot index, or all ones on a miss. A translation hitting several entries uses the lowest one.
- R12: An indexed write (op 1) to an index at or past the table size is ignored. A round-robin write (op 2) stores into slot `nxt_slot` and then advances it, wrapping to 0 after the last slot.
- R13: Reset and a clear (op 4) empty every entry and return `nxt_slot` to 0.
- R14: `rsp_valid` is high exactly one cycle after each request. A write to the table affects translations presented from the next cycle on. A translation in the same cycle as the write sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | 32 | Virtual address |
| req_asid | input | 8 | Address-space tag |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 double |
| req_status | input | 32 | Processor status word |
| fine_pages | input | 1 | Keep low two page-number bits in lookups |
| rsp_valid | output | 1 | Response strobe |
| rsp_pa | output | 32 | Physical address (zero on fault) |
| rsp_fault | output | 3 | Fault code |
| rsp_uncached | output | 1 | Uncached access |
| rsp_cattr | output | 3 | Cache attribute of the used half |
| rsp_badva | output | 32 | Faulting virtual address |
| rsp_vpn2 | output | 19 | Page-pair number for the handler |
| rsp_vpn2x | output | 2 | Low page-number bits for the handler |
| rsp_asid | output | 8 | Faulting tag |
| rsp_ctx_vpn2 | output | 19 | Context page-pair number |
| mnt_op | input | 3 | 0 idle, 1 indexed write, 2 round-robin write, 3 probe, 4 clear |
| mnt_index | input | IDX_W+1 | Slot for indexed write |
| mnt_vpn | input | 21 | Page number to write or probe |
| mnt_pmask | input | 8 | Size mask to write |
| mnt_asid | input | 8 | Tag to write or probe |
| mnt_glob | input | 1 | Global bit to write |
| mnt_pfn_ev | input | 20 | Even frame number |
| mnt_attr_ev | input | 3 | Even cache attribute |
| mnt_dirty_ev | input | 1 | Even dirty bit |
| mnt_valid_ev | input | 1 | Even valid bit |
| mnt_pfn_od | input | 20 | Odd frame number |
| mnt_attr_od | input | 3 | Odd cache attribute |
| mnt_dirty_od | input | 1 | Odd dirty bit |
| mnt_valid_od | input | 1 | Odd valid bit |
| prb_valid | output | 1 | Probe result strobe |
| prb_result | output | IDX_W+1 | Probe result slot or all ones |
| nxt_slot | output | IDX_W | Round-robin slot pointer |

## Verification
A maintenance write and a translation can land in the same cycle, and the translation may target the very page being written. The bench raises an indexed write for a new page together with a request for an address inside that page. It expects a refill code from that response and a good physical address from an identical request in the following cycle. Clear and round-robin writes are judged the same way, through probes and the `nxt_slot` output in the cycle after the operation.

// File: rtl/tlb_pair_pkg.sv
`timescale 1ns/1ps
// Shared widths, entry layout and encodings for the paired-page TLB.
// Assumes a 32-bit virtual address and 4 KiB frame granularity.
package tlb_pair_pkg;
    localparam int VA_W    = 32;
    localparam int VPN_LSB = 11;
    localparam int VPN_W   = VA_W - VPN_LSB;
    localparam int PM_W    = 8;
    localparam int ASID_W  = 8;
    localparam int PFN_W   = 20;
    localparam int PG_LSB  = 12;
    localparam int PA_W    = PFN_W + PG_LSB;
    localparam int ATTR_W  = 3;
    localparam int VPN2_W  = VPN_W - 2;

    typedef struct packed {
        logic [PFN_W-1:0]  pfn;
        logic [ATTR_W-1:0] cattr;
        logic              dirty;
        logic              valid;
    } half_t;

    typedef struct packed {
        logic              occ;
        logic [VPN_W-1:0]  vpn;
        logic [PM_W-1:0]   pmask;
        logic [ASID_W-1:0] asid;
        logic              glob;
        half_t             ev;
        half_t             od;
    } entry_t;

    typedef enum logic [2:0] {
        FLT_NONE      = 3'd0,
        FLT_ADR_FETCH = 3'd1,
        FLT_ADR_DATA  = 3'd2,
        FLT_RFL_FETCH = 3'd3,
        FLT_RFL_DATA  = 3'd4,
        FLT_INV_FETCH = 3'd5,
        FLT_INV_DATA  = 3'd6,
        FLT_MOD       = 3'd7
    } flt_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [2:0] {
        MNT_IDLE    = 3'd0,
        MNT_WR_IDX  = 3'd1,
        MNT_WR_NEXT = 3'd2,
        MNT_PROBE   = 3'd3,
        MNT_FLUSH   = 3'd4
    } mnt_e;

    // Entry match: page number outside the size mask, and tag or global.
    function automatic logic entry_hit(entry_t e, logic [VPN_W-1:0] key,
                                       logic [ASID_W-1:0] tag);
        logic [VPN_W-1:0] keep;
        keep = ~({{(VPN_W-PM_W-2){1'b0}}, e.pmask, 2'b00});
        return e.occ && (((key ^ e.vpn) & keep) == '0) &&
               (e.glob || (e.asid == tag));
    endfunction

    // Page shift from the size mask: 12 plus bit count rounded to even.
    function automatic logic [4:0] page_shift(logic [PM_W-1:0] pm);
        logic [4:0] cnt;
        cnt = '0;
        for (int i = 0; i < PM_W; i++) cnt = cnt + {4'b0, pm[i]};
        return 5'(PG_LSB) + {cnt[4:1], 1'b0};
    endfunction
endpackage

// File: rtl/tlb_entry_bank.sv
`timescale 1ns/1ps
// Entry storage: one register per slot plus the round-robin pointer.
// Assumes at most one write per cycle; clear has priority over writes.
module tlb_entry_bank
    import tlb_pair_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_idx_en,
    input  logic [IDX_W-1:0]     wr_index,
    input  logic                 wr_next_en,
    input  logic                 clear,
    input  entry_t               wr_data,
    output entry_t [N-1:0]       ents,
    output logic [IDX_W-1:0]     nxt
);
    logic             we;
    logic [IDX_W-1:0] wslot;

    // Pick the slot written this cycle.
    always_comb begin
        we    = wr_idx_en | wr_next_en;
        wslot = wr_next_en ? nxt : wr_index;
    end

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_slot
            // Hold one entry; cleared by reset or clear.
            always_ff @(posedge clk) begin
                if (!rst_n || clear)
                    ents[g] <= '0;
                else if (we && wslot == IDX_W'(g))
                    ents[g] <= wr_data;
            end
        end
    endgenerate

    // Round-robin pointer, advanced by each round-robin write.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            nxt <= '0;
        else if (wr_next_en)
            nxt <= (nxt == IDX_W'(N-1)) ? '0 : nxt + 1'b1;
    end
endmodule

// File: rtl/tlb_cam_port.sv
`timescale 1ns/1ps
// One associative lookup port: match every entry, lowest index wins.
// Purely combinational.
module tlb_cam_port
    import tlb_pair_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  entry_t [N-1:0]    ents,
    input  logic [VPN_W-1:0]  key_vpn,
    input  logic [ASID_W-1:0] key_asid,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx
);
    logic [N-1:0] mvec;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            assign mvec[g] = entry_hit(ents[g], key_vpn, key_asid);
        end
    endgenerate

    // Priority encode: scan downward so the lowest match is kept.
    always_comb begin
        hit     = |mvec;
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--)
            if (mvec[i]) hit_idx = IDX_W'(i);
    end
endmodule

// File: rtl/tlb_xlate_resp.sv
`timescale 1ns/1ps
// Translation datapath: key derivation, segment bypass, half selection,
// address composition, fault priority and the registered response.
// Assumes the matching entry's mask and halves are supplied combinationally.
module tlb_xlate_resp
    import tlb_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [1:0]        req_kind,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_status,
    input  logic              fine_pages,
    output logic [VPN_W-1:0]  lk_vpn,
    input  logic              hit,
    input  logic [PM_W-1:0]   hit_pmask,
    input  half_t             hit_ev,
    input  half_t             hit_od,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [2:0]        rsp_fault,
    output logic              rsp_uncached,
    output logic [ATTR_W-1:0] rsp_cattr,
    output logic [VA_W-1:0]   rsp_badva,
    output logic [VPN2_W-1:0] rsp_vpn2,
    output logic [1:0]        rsp_vpn2x,
    output logic [ASID_W-1:0] rsp_asid,
    output logic [VPN2_W-1:0] rsp_ctx_vpn2
);
    logic              seg_cached, seg_uncached, kernel, misal, is_fetch, is_store;
    logic [2:0]        size_mask;
    logic [4:0]        shift;
    half_t             half;
    logic [PA_W-1:0]   offm, pa_map, pa_direct;
    flt_e              flt;
    logic [PA_W-1:0]   pa_n;
    logic              unc_n;
    logic [ATTR_W-1:0] attr_n;
    logic              tlb_flt;

    // Lookup key: page number, low pair bits kept only in fine mode.
    always_comb begin
        lk_vpn = fine_pages ? req_va[VA_W-1:VPN_LSB]
                            : {req_va[VA_W-1:VPN_LSB+2], 2'b00};
    end

    // Segment, privilege and alignment decode.
    always_comb begin
        seg_cached   = req_va[31:29] == 3'b100;
        seg_uncached = req_va[31:29] == 3'b101;
        kernel       = (|(req_status & 32'h1000_0006)) || (req_status[4:3] == 2'b00);
        case (req_size)
            2'd0:    size_mask = 3'b000;
            2'd1:    size_mask = 3'b001;
            2'd2:    size_mask = 3'b011;
            default: size_mask = 3'b111;
        endcase
        misal    = |(req_va[2:0] & size_mask);
        is_fetch = req_kind == ACC_FETCH;
        is_store = req_kind == ACC_STORE;
    end

    // Half selection and physical address composition for a hit.
    always_comb begin
        shift     = page_shift(hit_pmask);
        half      = req_va[shift] ? hit_od : hit_ev;
        offm      = (PA_W'(1) << shift) - PA_W'(1);
        pa_map    = ({half.pfn, {PG_LSB{1'b0}}} & ~offm) | (req_va & offm);
        pa_direct = {3'b000, req_va[28:0]};
    end

    // Fault priority and next response value.
    always_comb begin
        flt    = FLT_NONE;
        pa_n   = '0;
        attr_n = '0;
        if (seg_cached) begin
            if (!kernel || misal) flt = is_fetch ? FLT_ADR_FETCH : FLT_ADR_DATA;
            else                  pa_n = pa_direct;
        end else if (seg_uncached) begin
            pa_n = pa_direct;
        end else if (misal) begin
            flt = is_fetch ? FLT_ADR_FETCH : FLT_ADR_DATA;
        end else if (!hit) begin
            flt = is_fetch ? FLT_RFL_FETCH : FLT_RFL_DATA;
        end else if (!half.valid) begin
            flt = is_fetch ? FLT_INV_FETCH : FLT_INV_DATA;
        end else if (is_store && !half.dirty) begin
            flt = FLT_MOD;
        end else begin
            pa_n   = pa_map;
            attr_n = half.cattr;
        end
        unc_n   = (flt == FLT_NONE) && req_va[31] && req_va[29];
        tlb_flt = (flt != FLT_NONE) && (flt != FLT_ADR_FETCH) && (flt != FLT_ADR_DATA);
    end

    // Response register, loaded once per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_pa       <= '0;
            rsp_fault    <= '0;
            rsp_uncached <= 1'b0;
            rsp_cattr    <= '0;
            rsp_badva    <= '0;
            rsp_vpn2     <= '0;
            rsp_vpn2x    <= '0;
            rsp_asid     <= '0;
            rsp_ctx_vpn2 <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_pa       <= pa_n;
                rsp_fault    <= flt;
                rsp_uncached <= unc_n;
                rsp_cattr    <= attr_n;
                rsp_badva    <= (flt != FLT_NONE) ? req_va : '0;
                rsp_vpn2     <= tlb_flt ? lk_vpn[VPN_W-1:2] : '0;
                rsp_vpn2x    <= tlb_flt ? lk_vpn[1:0] : '0;
                rsp_asid     <= tlb_flt ? req_asid : '0;
                rsp_ctx_vpn2 <= tlb_flt ? lk_vpn[VPN_W-1:2] : '0;
            end
        end
    end
endmodule

// File: rtl/tlb_pair_xlate.sv
`timescale 1ns/1ps
// Top of the paired-page TLB: entry bank, two lookup ports (translate and
// probe), translation datapath and the registered probe result.
// Assumes one maintenance operation per cycle.
module tlb_pair_xlate
    import tlb_pair_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [31:0]      req_va,
    input  logic [7:0]       req_asid,
    input  logic [1:0]       req_kind,
    input  logic [1:0]       req_size,
    input  logic [31:0]      req_status,
    input  logic             fine_pages,
    output logic             rsp_valid,
    output logic [31:0]      rsp_pa,
    output logic [2:0]       rsp_fault,
    output logic             rsp_uncached,
    output logic [2:0]       rsp_cattr,
    output logic [31:0]      rsp_badva,
    output logic [18:0]      rsp_vpn2,
    output logic [1:0]       rsp_vpn2x,
    output logic [7:0]       rsp_asid,
    output logic [18:0]      rsp_ctx_vpn2,
    input  logic [2:0]       mnt_op,
    input  logic [IDX_W:0]   mnt_index,
    input  logic [20:0]      mnt_vpn,
    input  logic [7:0]       mnt_pmask,
    input  logic [7:0]       mnt_asid,
    input  logic             mnt_glob,
    input  logic [19:0]      mnt_pfn_ev,
    input  logic [2:0]       mnt_attr_ev,
    input  logic             mnt_dirty_ev,
    input  logic             mnt_valid_ev,
    input  logic [19:0]      mnt_pfn_od,
    input  logic [2:0]       mnt_attr_od,
    input  logic             mnt_dirty_od,
    input  logic             mnt_valid_od,
    output logic             prb_valid,
    output logic [IDX_W:0]   prb_result,
    output logic [IDX_W-1:0] nxt_slot
);
    entry_t [NUM_ENTRIES-1:0] ents;
    entry_t                   wr_data;
    entry_t                   xl_ent;
    logic                     wr_idx_en, wr_next_en, clear, do_probe;
    logic [VPN_W-1:0]         lk_vpn;
    logic                     xl_hit, pb_hit;
    logic [IDX_W-1:0]         xl_idx, pb_idx;

    // Decode maintenance operation and assemble the written entry.
    always_comb begin
        wr_idx_en  = (mnt_op == MNT_WR_IDX) && (32'(mnt_index) < NUM_ENTRIES);
        wr_next_en = mnt_op == MNT_WR_NEXT;
        clear      = mnt_op == MNT_FLUSH;
        do_probe   = mnt_op == MNT_PROBE;
        wr_data    = '{occ: 1'b1, vpn: mnt_vpn, pmask: mnt_pmask, asid: mnt_asid,
                       glob: mnt_glob,
                       ev: '{pfn: mnt_pfn_ev, cattr: mnt_attr_ev,
                             dirty: mnt_dirty_ev, valid: mnt_valid_ev},
                       od: '{pfn: mnt_pfn_od, cattr: mnt_attr_od,
                             dirty: mnt_dirty_od, valid: mnt_valid_od}};
        xl_ent     = ents[xl_idx];
    end

    tlb_entry_bank #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_idx_en(wr_idx_en), .wr_index(mnt_index[IDX_W-1:0]),
        .wr_next_en(wr_next_en), .clear(clear), .wr_data(wr_data),
        .ents(ents), .nxt(nxt_slot)
    );

    tlb_cam_port #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_cam_xl (
        .ents(ents), .key_vpn(lk_vpn), .key_asid(req_asid),
        .hit(xl_hit), .hit_idx(xl_idx)
    );

    tlb_cam_port #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_cam_pb (
        .ents(ents), .key_vpn(mnt_vpn), .key_asid(mnt_asid),
        .hit(pb_hit), .hit_idx(pb_idx)
    );

    tlb_xlate_resp u_xl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_va(req_va), .req_asid(req_asid),
        .req_kind(req_kind), .req_size(req_size), .req_status(req_status),
        .fine_pages(fine_pages), .lk_vpn(lk_vpn),
        .hit(xl_hit), .hit_pmask(xl_ent.pmask), .hit_ev(xl_ent.ev), .hit_od(xl_ent.od),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
        .rsp_uncached(rsp_uncached), .rsp_cattr(rsp_cattr), .rsp_badva(rsp_badva),
        .rsp_vpn2(rsp_vpn2), .rsp_vpn2x(rsp_vpn2x), .rsp_asid(rsp_asid),
        .rsp_ctx_vpn2(rsp_ctx_vpn2)
    );

    // Registered probe result: lowest matching slot or all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prb_valid  <= 1'b0;
            prb_result <= '0;
        end else begin
            prb_valid <= do_probe;
            if (do_probe) prb_result <= pb_hit ? {1'b0, pb_idx} : '1;
        end
    end
endmodule

// File: rtl/tlb_pair_xlate_chk.sv
`timescale 1ns/1ps
// Property checker for tlb_pair_xlate, attached by bind below.
module tlb_pair_xlate_chk #(
    parameter int NUM_ENTRIES = 8,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [31:0]      req_va,
    input logic [1:0]       req_kind,
    input logic             rsp_valid,
    input logic [31:0]      rsp_pa,
    input logic [2:0]       rsp_fault,
    input logic [31:0]      rsp_badva,
    input logic [2:0]       mnt_op,
    input logic             prb_valid,
    input logic [IDX_W-1:0] nxt_slot
);
    logic [IDX_W-1:0] nxt_exp;
    always_comb nxt_exp = (nxt_slot == IDX_W'(NUM_ENTRIES-1)) ? '0 : nxt_slot + 1'b1;

    // R14
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R14
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R8
    uncached_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_va[31:29] == 3'b101) |=>
        (rsp_fault == 3'd0 && rsp_pa == {3'b000, $past(req_va[28:0])}));
    // R6
    modified_store_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind != 2'd1) |=> rsp_fault != 3'd7);
    // R7
    bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_fault == 3'd0 || rsp_badva == $past(req_va)));
    // R12
    next_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mnt_op == 3'd2 |=> nxt_slot == $past(nxt_exp));
    // R13
    clear_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mnt_op == 3'd4 |=> nxt_slot == '0);
    // R11
    probe_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mnt_op == 3'd3 |=> prb_valid);
endmodule

bind tlb_pair_xlate tlb_pair_xlate_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_kind(req_kind), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
    .rsp_fault(rsp_fault), .rsp_badva(rsp_badva), .mnt_op(mnt_op),
    .prb_valid(prb_valid), .nxt_slot(nxt_slot)
);

// File: tb/tlb_pair_xlate_bench.sv
`timescale 1ns/1ps
module tlb_pair_xlate_bench;
    localparam int N     = 8;
    localparam int IDX_W = $clog2(N);

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, fine_pages = 0;
    logic [31:0] req_va = 0, req_status = 0;
    logic [7:0]  req_asid = 0;
    logic [1:0]  req_kind = 0, req_size = 0;
    logic        rsp_valid, rsp_uncached;
    logic [31:0] rsp_pa, rsp_badva;
    logic [2:0]  rsp_fault, rsp_cattr;
    logic [18:0] rsp_vpn2, rsp_ctx_vpn2;
    logic [1:0]  rsp_vpn2x;
    logic [7:0]  rsp_asid;
    logic [2:0]  mnt_op = 0;
    logic [IDX_W:0] mnt_index = 0;
    logic [20:0] mnt_vpn = 0;
    logic [7:0]  mnt_pmask = 0, mnt_asid = 0;
    logic        mnt_glob = 0, mnt_dirty_ev = 0, mnt_valid_ev = 0, mnt_dirty_od = 0, mnt_valid_od = 0;
    logic [19:0] mnt_pfn_ev = 0, mnt_pfn_od = 0;
    logic [2:0]  mnt_attr_ev = 3'd3, mnt_attr_od = 3'd2;
    logic        prb_valid;
    logic [IDX_W:0]   prb_result;
    logic [IDX_W-1:0] nxt_slot;

    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    tlb_pair_xlate #(.NUM_ENTRIES(N)) u_tlb_pair_xlate (.*);

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_ent(input logic [2:0] op, input logic [IDX_W:0] idx, input logic [20:0] vpn,
                           input logic [7:0] pm, input logic [7:0] asid, input logic g,
                           input logic [19:0] p0, input logic v0, input logic d0,
                           input logic [19:0] p1, input logic v1, input logic d1);
        mnt_op = op; mnt_index = idx; mnt_vpn = vpn; mnt_pmask = pm; mnt_asid = asid;
        mnt_glob = g; mnt_pfn_ev = p0; mnt_valid_ev = v0; mnt_dirty_ev = d0;
        mnt_pfn_od = p1; mnt_valid_od = v1; mnt_dirty_od = d1;
    endtask

    task automatic wr(input logic [2:0] op, input logic [IDX_W:0] idx, input logic [20:0] vpn,
                      input logic [7:0] pm, input logic [7:0] asid, input logic g,
                      input logic [19:0] p0, input logic v0, input logic d0,
                      input logic [19:0] p1, input logic v1, input logic d1);
        set_ent(op, idx, vpn, pm, asid, g, p0, v0, d0, p1, v1, d1);
        tick();
        mnt_op = 0;
    endtask

    task automatic set_req(input logic [31:0] va, input logic [7:0] asid, input logic [1:0] kind,
                           input logic [1:0] size, input logic [31:0] st);
        req_valid = 1; req_va = va; req_asid = asid; req_kind = kind; req_size = size; req_status = st;
    endtask

    task automatic xl(input logic [31:0] va, input logic [7:0] asid, input logic [1:0] kind,
                      input logic [1:0] size, input logic [31:0] st);
        set_req(va, asid, kind, size, st);
        tick();
        req_valid = 0;
    endtask

    task automatic probe(input logic [20:0] vpn, input logic [7:0] asid);
        mnt_op = 3'd3; mnt_vpn = vpn; mnt_asid = asid;
        tick();
        mnt_op = 0;
    endtask

    task automatic t_reset();
        chk("R14 rsp_valid at reset", rsp_valid, 0);
        chk("R13 nxt_slot at reset", nxt_slot, 0);
        chk("R13 prb_valid at reset", prb_valid, 0);
        probe(21'h0, 8'h0);
        chk("R1 unwritten entries never match", prb_result, 4'hF);
    endtask

    task automatic t_basic();
        wr(3'd1, 0, 21'h800, 8'h00, 8'd5, 0, 20'h12345, 1, 1, 20'h54321, 1, 0);
        xl(32'h0040_0ABC, 5, 0, 2, 0);
        chk("R14 rsp_valid one cycle after request", rsp_valid, 1);
        chk("R3 even half PA", rsp_pa, 32'h1234_5ABC);
        chk("R4 even cache attr", rsp_cattr, 3);
        chk("R5 hit no fault", rsp_fault, 0);
        chk("R7 no-fault badva zero", rsp_badva, 0);
        tick();
        chk("R14 rsp_valid drops", rsp_valid, 0);
        xl(32'h0040_1ABC, 5, 0, 2, 0);
        chk("R3 odd half PA", rsp_pa, 32'h5432_1ABC);
        chk("R4 odd cache attr", rsp_cattr, 2);
        xl(32'h0040_1ABC, 6, 0, 2, 0);
        chk("R1 tag mismatch refill", rsp_fault, 4);
        chk("R7 badva", rsp_badva, 32'h0040_1ABC);
        chk("R7 vpn2", rsp_vpn2, 19'h200);
        chk("R7 ctx vpn2", rsp_ctx_vpn2, 19'h200);
        chk("R7 vpn2x", rsp_vpn2x, 0);
        chk("R7 asid", rsp_asid, 6);
        xl(32'h0040_1ABC, 5, 1, 2, 0);
        chk("R6 store to clean half", rsp_fault, 7);
        chk("R6 modified asid", rsp_asid, 5);
        xl(32'h0040_0ABC, 5, 1, 2, 0);
        chk("R6 store to dirty half", rsp_fault, 0);
        xl(32'h0040_1ABC, 5, 2, 2, 0);
        chk("R6 fetch from clean half", rsp_fault, 0);
        xl(32'h0040_1ABC, 6, 2, 2, 0);
        chk("R5 fetch refill", rsp_fault, 3);
    endtask

    task automatic t_global_invalid();
        wr(3'd1, 1, 21'h1000, 8'h00, 8'd9, 1, 20'h0, 0, 0, 20'h00AAA, 1, 0);
        xl(32'h0080_0010, 3, 0, 2, 0);
        chk("R5 data invalid", rsp_fault, 6);
        xl(32'h0080_0010, 3, 2, 2, 0);
        chk("R5 fetch invalid", rsp_fault, 5);
        xl(32'h0080_1010, 3, 0, 2, 0);
        chk("R1 global match PA", rsp_pa, 32'h00AA_A010);
    endtask

    task automatic t_large_page();
        wr(3'd1, 2, 21'h20000, 8'h0F, 8'd0, 1, 20'h44440, 1, 1, 20'h33337, 1, 1);
        xl(32'h1001_2345, 0, 0, 0, 0);
        chk("R4 64K odd PA aligned", rsp_pa, 32'h3333_2345);
        xl(32'h1000_F000, 0, 0, 0, 0);
        chk("R3 64K even PA", rsp_pa, 32'h4444_F000);
        xl(32'h1002_0000, 0, 0, 0, 0);
        chk("R1 outside mask refill", rsp_fault, 4);
        chk("R7 large vpn2", rsp_vpn2, 19'h8010);
    endtask

    task automatic t_fine_pages();
        fine_pages = 1;
        xl(32'h0040_0800, 5, 0, 0, 0);
        chk("R2 fine mode keeps low bits", rsp_fault, 4);
        chk("R2 vpn2x", rsp_vpn2x, 1);
        chk("R2 vpn2", rsp_vpn2, 19'h200);
        fine_pages = 0;
        xl(32'h0040_0800, 5, 0, 0, 0);
        chk("R2 normal mode clears low bits", rsp_pa, 32'h1234_5800);
    endtask

    task automatic t_bypass();
        xl(32'h8000_1000, 0, 0, 2, 32'h0);
        chk("R8 cached window PA", rsp_pa, 32'h0000_1000);
        chk("R10 cached window cacheable", rsp_uncached, 0);
        xl(32'hA000_2000, 0, 0, 2, 32'h10);
        chk("R8 uncached window PA", rsp_pa, 32'h0000_2000);
        chk("R10 uncached window flag", rsp_uncached, 1);
        xl(32'h8000_1000, 0, 0, 2, 32'h10);
        chk("R9 user data address error", rsp_fault, 2);
        xl(32'h8000_1000, 0, 2, 2, 32'h08);
        chk("R9 supervisor fetch address error", rsp_fault, 1);
        xl(32'h8000_1000, 0, 0, 2, 32'h12);
        chk("R9 user with low status bit is kernel", rsp_fault, 0);
        xl(32'h8000_1002, 0, 0, 2, 32'h0);
        chk("R8 misaligned kernel window", rsp_fault, 2);
        xl(32'hA000_2001, 0, 0, 2, 32'h10);
        chk("R8 uncached window never faults", rsp_fault, 0);
    endtask

    task automatic t_uncached_misalign();
        wr(3'd1, 3, 21'h1C0000, 8'h00, 8'd0, 1, 20'h00777, 1, 1, 20'h0, 0, 0);
        xl(32'hE000_0120, 0, 0, 2, 0);
        chk("R10 mapped uncached PA", rsp_pa, 32'h0077_7120);
        chk("R10 mapped uncached flag", rsp_uncached, 1);
        xl(32'hE000_0121, 0, 0, 1, 0);
        chk("R10 misaligned over hit", rsp_fault, 2);
        xl(32'h0900_0001, 0, 0, 2, 0);
        chk("R10 misaligned over refill", rsp_fault, 2);
    endtask

    task automatic t_probe_prio();
        probe(21'h1000, 0);
        chk("R11 probe global", prb_result, 1);
        chk("R11 probe strobe", prb_valid, 1);
        probe(21'h800, 5);
        chk("R11 probe tag", prb_result, 0);
        probe(21'h800, 7);
        chk("R11 probe miss", prb_result, 4'hF);
        wr(3'd1, 5, 21'h800, 8'h00, 8'd7, 0, 20'h11111, 1, 1, 20'h0, 0, 0);
        wr(3'd1, 6, 21'h800, 8'h00, 8'd7, 0, 20'h22222, 1, 1, 20'h0, 0, 0);
        probe(21'h800, 7);
        chk("R11 lowest slot wins probe", prb_result, 5);
        xl(32'h0040_0004, 7, 0, 2, 0);
        chk("R11 lowest slot wins translation", rsp_pa, 32'h1111_1004);
    endtask

    task automatic t_same_cycle();
        set_ent(3'd1, 4, 21'h5000, 8'h00, 8'd0, 1, 20'h0BEEF, 1, 1, 20'h0, 0, 0);
        set_req(32'h0280_0004, 0, 0, 2, 0);
        tick();
        mnt_op = 0;
        chk("R14 same-cycle sees old table", rsp_fault, 4);
        tick();
        chk("R14 next cycle sees new entry", rsp_pa, 32'h0BEE_F004);
        chk("R14 next cycle no fault", rsp_fault, 0);
        req_valid = 0;
    endtask

    task automatic t_write_range_next();
        wr(3'd1, 8, 21'h3000, 8'h00, 8'd0, 1, 20'h1, 1, 1, 20'h1, 1, 1);
        probe(21'h3000, 0);
        chk("R12 out-of-range write ignored", prb_result, 4'hF);
        chk("R12 pointer before round-robin", nxt_slot, 0);
        wr(3'd2, 0, 21'h3000, 8'h00, 8'd0, 1, 20'h1, 1, 1, 20'h1, 1, 1);
        chk("R12 pointer advanced", nxt_slot, 1);
        probe(21'h3000, 0);
        chk("R12 round-robin slot", prb_result, 0);
        for (int i = 1; i < N; i++) wr(3'd2, 0, 21'h4000, 8'h00, 8'd0, 1, 20'h1, 1, 1, 20'h1, 1, 1);
        chk("R12 pointer wraps", nxt_slot, 0);
    endtask

    task automatic t_flush();
        wr(3'd2, 0, 21'h4000, 8'h00, 8'd0, 1, 20'h1, 1, 1, 20'h1, 1, 1);
        chk("R13 pointer nonzero before clear", nxt_slot, 1);
        mnt_op = 3'd4;
        tick();
        mnt_op = 0;
        chk("R13 pointer cleared", nxt_slot, 0);
        probe(21'h4000, 0);
        chk("R13 entries cleared", prb_result, 4'hF);
        xl(32'h0080_1010, 3, 0, 2, 0);
        chk("R13 translation refill after clear", rsp_fault, 4);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_basic();
        t_global_invalid();
        t_large_page();
        t_fine_pages();
        t_bypass();
        t_uncached_misalign();
        t_probe_prio();
        t_same_cycle();
        t_write_range_next();
        t_flush();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule